// File: doc/BRIEF.md
# MFM Write Stream Escape Interpreter

This block sits between a byte-wide DMA source that carries a disk write stream and the bit-level MFM serializer. Ordinary bytes pass straight through to the serializer. A reserved escape byte (0x99) turns the byte after it into a command. A command can produce a mark byte that must be written with clock bits missing, or an address or data identifier. It can also open a raw window in which escape detection is off, make the block emit the running CRC-16, or end the write.

Both sides use a valid/ready handshake. The output is a single registered stage that carries the byte and a mark flag. The serializer uses the flag to decide when to drop clock bits. A typical sector write has three stages. First comes a gap and sync preamble, then escaped sync marks and an identifier, then a raw window that carries the 512 payload bytes. The stream ends with a CRC command, a short gap and the stop command.

Top module: `mfm_escape_parser`

## Requirements
- R1: After reset, out_valid, stopped and cmd_err are 0 and in_ready is 1.
- R2: An input byte other than 0x99, outside a raw window, is emitted unchanged with out_mark=0, in arrival order.
- R3: 0x99 followed by 0xA1 or 0xC2 emits that second byte with out_mark=1.
- R4: 0x99 followed by 0xFB, 0xFE or 0xFC emits that second byte with out_mark=0.
- R5: 0x99 followed by 0x0F emits nothing itself. The next 512 input bytes are emitted verbatim with out_mark=0, including any 0x99. After those 512 bytes, escape detection resumes.
- R6: The CRC is CRC-16 with polynomial 0x1021, processed MSB first, and reset is 0xFFFF. An 0xA1 mark that follows any emitted byte other than an 0xA1 mark presets the CRC to 0xFFFF before that mark is folded in. Every emitted byte except 0xC2 marks and CRC bytes updates the CRC.
- R7: 0x99 followed by 0x04 emits the CRC high byte and then the low byte, both with out_mark=0. Emitting them leaves the CRC unchanged.
- R8: 0x99 followed by 0x08 sets stopped. While stopped, in_ready stays 1 and every input byte is dropped without output until reset.
- R9: 0x99 followed by any other byte, including a second 0x99, emits nothing and sets cmd_err, which holds until reset.
- R10: While out_valid is 1 and out_ready is 0, out_data and out_mark hold. No byte is lost or repeated under backpressure.
- R11: An escape byte outside a raw window produces no output of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte from the DMA stream |
| in_ready | output | 1 | Block can accept the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Byte for the serializer |
| out_mark | output | 1 | Write this byte with missing clock bits |
| out_ready | input | 1 | Serializer takes the output byte |
| stopped | output | 1 | Stop command seen; input is being discarded |
| cmd_err | output | 1 | Undefined command seen (sticky) |

## Verification
The bench pushes payload bytes equal to 0x99 and 0x08 through the raw window. A design that left escape detection on there would swallow those bytes or stop early. The bench then sends a CRC command right after the 512th payload byte. An off-by-one counter would either emit the 0x99 or miss the command. CRC preset is checked by putting a plain byte before an 0xA1 mark: a design that never presets reports a different CRC. The full sector frame runs again under random serializer stalls, which exposes any design that drops or repeats a held byte.

// File: rtl/mfm_escape_parser.sv
module mfm_escape_parser #(
  parameter logic [7:0] ESC_BYTE = 8'h99,
  parameter int RAW_LEN = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_mark,
  input  logic       out_ready,
  output logic       stopped,
  output logic       cmd_err
);
  localparam int CW = $clog2(RAW_LEN + 1);
  localparam logic [7:0] C_SYNC = 8'hA1, C_INDEX = 8'hC2;
  localparam logic [7:0] C_ID_D = 8'hFB, C_ID_A = 8'hFE, C_ID_I = 8'hFC;
  localparam logic [7:0] C_RAW = 8'h0F, C_CRC = 8'h04, C_STOP = 8'h08;

  typedef enum logic [2:0] {S_PLAIN, S_ESC, S_RAW, S_CRCH, S_CRCL, S_STOP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [15:0] crc;
  logic in_sync;

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  wire out_free = !out_valid || out_ready;
  wire accept = in_valid && in_ready;
  assign stopped = (st == S_STOP);
  assign in_ready = stopped || (out_free && st != S_CRCH && st != S_CRCL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PLAIN;
      cnt <= '0;
      crc <= 16'hFFFF;
      in_sync <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      out_mark <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_PLAIN: if (accept) begin
          if (in_data == ESC_BYTE) st <= S_ESC;
          else begin
            out_valid <= 1'b1; out_data <= in_data; out_mark <= 1'b0;
            crc <= crc_upd(crc, in_data); in_sync <= 1'b0;
          end
        end
        S_ESC: if (accept) begin
          st <= S_PLAIN;
          case (in_data)
            C_SYNC: begin
              out_valid <= 1'b1; out_data <= in_data; out_mark <= 1'b1;
              crc <= crc_upd(in_sync ? crc : 16'hFFFF, in_data);
              in_sync <= 1'b1;
            end
            C_INDEX: begin
              out_valid <= 1'b1; out_data <= in_data; out_mark <= 1'b1;
              in_sync <= 1'b0;
            end
            C_ID_D, C_ID_A, C_ID_I: begin
              out_valid <= 1'b1; out_data <= in_data; out_mark <= 1'b0;
              crc <= crc_upd(crc, in_data); in_sync <= 1'b0;
            end
            C_RAW: begin st <= S_RAW; cnt <= CW'(RAW_LEN); end
            C_CRC: st <= S_CRCH;
            C_STOP: st <= S_STOP;
            default: cmd_err <= 1'b1;
          endcase
        end
        S_RAW: if (accept) begin
          out_valid <= 1'b1; out_data <= in_data; out_mark <= 1'b0;
          crc <= crc_upd(crc, in_data); in_sync <= 1'b0;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_PLAIN;
        end
        S_CRCH: if (out_free) begin
          out_valid <= 1'b1; out_data <= crc[15:8]; out_mark <= 1'b0;
          st <= S_CRCL;
        end
        S_CRCL: if (out_free) begin
          out_valid <= 1'b1; out_data <= crc[7:0]; out_mark <= 1'b0;
          in_sync <= 1'b0; st <= S_PLAIN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mfm_escape_parser_props.sv
module mfm_escape_parser_props (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_mark,
  input logic       out_ready,
  input logic       stopped,
  input logic       cmd_err
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mark));
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped);
  a_r8_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !out_valid |=> !out_valid);
  a_r8_stop_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> in_ready);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  a_r3_mark_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mark |-> (out_data == 8'hA1 || out_data == 8'hC2));
endmodule

bind mfm_escape_parser mfm_escape_parser_props u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_mark(out_mark),
  .out_ready(out_ready), .stopped(stopped), .cmd_err(cmd_err)
);

// File: tb/mfm_escape_parser_test.sv
`timescale 1ns/1ps
module mfm_escape_parser_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_mark, stopped, cmd_err;
  logic [7:0] out_data;
  int n_tests = 0, n_fail = 0;
  logic stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0] cap[$];
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  mfm_escape_parser uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_mark(out_mark), .out_ready(out_ready), .stopped(stopped), .cmd_err(cmd_err)
  );

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) cap.push_back({out_mark, out_data});

  // entry: esc, byte, emits, mark, err
  localparam logic [11:0] VEC [0:9] = '{
    {1'b0, 8'h4E, 3'b100}, {1'b0, 8'h00, 3'b100}, {1'b0, 8'hA1, 3'b100},
    {1'b1, 8'hA1, 3'b110}, {1'b1, 8'hC2, 3'b110}, {1'b1, 8'hFB, 3'b100},
    {1'b1, 8'hFE, 3'b100}, {1'b1, 8'hFC, 3'b100}, {1'b1, 8'h55, 3'b001},
    {1'b1, 8'h99, 3'b001}
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[15] != d[7-k]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cap.delete();
  endtask

  task automatic drain;
    repeat (40) @(negedge clk);
  endtask

  task automatic cmp_q(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_q.size(); i++)
      if (bad < 0 && (i >= cap.size() || cap[i] != exp_q[i])) bad = i;
    chk(cap.size() == exp_q.size(), {tag, " count"}, cap.size(), exp_q.size());
    chk(bad < 0, {tag, " content"}, (bad < 0 || bad >= cap.size()) ? 0 : int'(cap[bad]),
        bad < 0 ? 0 : int'(exp_q[bad]));
  endtask

  task automatic run_frame(input string tag);
    logic [15:0] c;
    logic [7:0] p;
    do_reset();
    exp_q.delete();
    repeat (10) begin send(8'h4E); exp_q.push_back({1'b0, 8'h4E}); end
    repeat (6) begin send(8'h00); exp_q.push_back({1'b0, 8'h00}); end
    c = 16'hFFFF;
    repeat (3) begin send(8'h99); send(8'hA1); exp_q.push_back({1'b1, 8'hA1}); c = ref_crc(c, 8'hA1); end
    send(8'h99); send(8'hFB); exp_q.push_back({1'b0, 8'hFB}); c = ref_crc(c, 8'hFB);
    send(8'h99); send(8'h0F);
    for (int i = 0; i < 512; i++) begin
      p = (i % 7 == 3) ? 8'h99 : (i % 11 == 5) ? 8'h08 : 8'(i * 37 + 1);
      send(p); exp_q.push_back({1'b0, p}); c = ref_crc(c, p);
    end
    send(8'h99); send(8'h04);
    exp_q.push_back({1'b0, c[15:8]}); exp_q.push_back({1'b0, c[7:0]});
    repeat (4) begin send(8'h4E); exp_q.push_back({1'b0, 8'h4E}); end
    send(8'h99); send(8'h08);
    drain();
    cmp_q({tag, " R5 R6 R7 R10 frame"});
    chk(stopped == 1'b1, {tag, " R8 stopped"}, stopped, 1);
    send(8'h4E); send(8'h99); send(8'hA1);
    drain();
    chk(cap.size() == exp_q.size(), {tag, " R8 drop after stop"}, cap.size(), exp_q.size());
    chk(cmd_err == 1'b0, {tag, " R9 no err"}, cmd_err, 0);
  endtask

  initial begin
    bit err_exp;
    logic [15:0] c;
    do_reset();
    @(negedge clk);
    chk(out_valid == 0 && stopped == 0 && cmd_err == 0 && in_ready == 1, "R1 reset state",
        {out_valid, stopped, cmd_err, in_ready}, 4'b0001);

    err_exp = 0;
    foreach (VEC[i]) begin
      cap.delete();
      if (VEC[i][11]) send(8'h99);
      send(VEC[i][10:3]);
      drain();
      err_exp = err_exp | VEC[i][0];
      // R2 R3 R4 R9 R11: emitted count, byte and mark
      chk(cap.size() == int'(VEC[i][2]), $sformatf("R2/R3/R4/R11 vec%0d count", i), cap.size(), VEC[i][2]);
      if (VEC[i][2] && cap.size() > 0)
        chk(cap[0] == {VEC[i][1], VEC[i][10:3]}, $sformatf("R3 R4 vec%0d byte", i), cap[0], {VEC[i][1], VEC[i][10:3]});
      chk(cmd_err == err_exp, $sformatf("R9 vec%0d err", i), cmd_err, err_exp);
    end

    // R6: reset value without a mark, then preset by A1 after a plain byte
    do_reset();
    send(8'h12); send(8'h99); send(8'h04);
    c = ref_crc(16'hFFFF, 8'h12);
    exp_q.delete();
    exp_q.push_back({1'b0, 8'h12}); exp_q.push_back({1'b0, c[15:8]}); exp_q.push_back({1'b0, c[7:0]});
    drain();
    cmp_q("R6 R7 reset crc");
    cap.delete();
    send(8'h99); send(8'hA1); send(8'h99); send(8'hC2); send(8'h99); send(8'h04);
    c = ref_crc(16'hFFFF, 8'hA1);
    exp_q.delete();
    exp_q.push_back({1'b1, 8'hA1}); exp_q.push_back({1'b1, 8'hC2});
    exp_q.push_back({1'b0, c[15:8]}); exp_q.push_back({1'b0, c[7:0]});
    drain();
    cmp_q("R6 preset on A1");

    run_frame("ready");
    stall_en = 1'b1;
    run_frame("stall");
    stall_en = 1'b0;
    do_reset();
    drain();
    chk(stopped == 0 && out_valid == 0, "R1 R8 reset clears stop", {stopped, out_valid}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule